// File: doc/BRIEF.md
# DMA Descriptor Buffer Walker

The walker accepts one DMA descriptor made of two 64-bit words. It turns the descriptor into a stream of cache-block transfer requests, one block of 32 bytes per request. Each request carries a byte address, a header byte offset and a flag that names the buffer it belongs to. The first word always describes buffer A. The second word has two meanings. In ring mode it describes an optional buffer B. In chain mode it carries the address of the next descriptor. A mode input, sampled when the descriptor is accepted, chooses between the two.

When the last block has been accepted, the walker pulses `done` for one cycle. In that cycle it also reports an interrupt if the descriptor asked for one, the link pointer if chain mode is active, and an error flag if the descriptor was malformed. A malformed descriptor issues no requests. For receive channels the block also builds the two write-back words. These keep every address, size and flag field of the held descriptor and replace only the status field and the packet-length field with the values presented on `rx_status` and `rx_len`.

The controller is a four-state machine:
- `ST_IDLE` waits for a descriptor. It goes to `ST_WALK_A` when the descriptor is well formed, and to `ST_FINISH` when it is malformed.
- `ST_WALK_A` walks buffer A. It goes to `ST_WALK_B` or `ST_FINISH` when its last block is accepted.
- `ST_WALK_B` walks buffer B. It goes to `ST_FINISH` when its last block is accepted.
- `ST_FINISH` is the single done cycle. It always returns to `ST_IDLE`.

Top module: `dma_dscr_walker`

## Requirements
- R1: After reset `dscr_ready` is 1 and `req_valid`, `done`, `irq` and `err` are 0. No request is offered while `dscr_ready` is 1.
- R2: A size field (bits 48:40 of either word) holding N from 1 to 511 gives N blocks, and the value 0 gives 512 blocks. Request k of a buffer has address (address field of bits 39:5, shifted left by 5) + 32·k, modulo 2^40.
- R3: In ring mode (`chain_mode`=0), when word B bit 49 is 1, buffer B (word B bits 39:5, size bits 48:40) is walked after buffer A with `req_buf`=1. When bit 49 is 0, only buffer A is walked with `req_buf`=0, whatever the B address and size fields hold.
- R4: In chain mode no buffer B is walked. At `done`, `next_ptr_valid` is 1 and `next_ptr` equals word B bits 39:4 shifted left by 4. In ring mode `next_ptr_valid` stays 0.
- R5: The header offset (word A bits 4:0) appears on `req_offset` of the first request of buffer A when word A bit 50 is 0, and of the first request of buffer B when bit 50 is 1. Every other request carries offset 0.
- R6: When word A bit 50 is 1 in chain mode, or with word B bit 49 equal to 0, the descriptor is malformed. It issues no requests, and `done` and `err` are 1 in the cycle after it is accepted.
- R7: With `tx_strict`=1, a descriptor is malformed (handled as in R6) if bit 40 of word A is 1, or if buffer B is walked and bit 40 of word B is 1. With `tx_strict`=0, odd sizes are walked normally.
- R8: `done` is a one-cycle pulse in the cycle after the last request is accepted. `irq` is 1 in that cycle exactly when word A bit 49 is 1 and the descriptor is not malformed.
- R9: While `req_valid` is 1 and `req_ready` is 0, the request address, offset and buffer flag hold unchanged and `req_valid` stays 1.
- R10: In the `done` cycle, `wb_a` equals {`rx_status`, word A bits 50:0} and `wb_b` equals {`rx_len`, word B bits 49:0} of the accepted descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dscr_valid | input | 1 | Descriptor presented |
| dscr_ready | output | 1 | Walker idle, ready to accept a descriptor |
| dscr_a | input | 64 | Descriptor first word |
| dscr_b | input | 64 | Descriptor second word |
| chain_mode | input | 1 | 1 selects chain mode, 0 selects ring mode |
| tx_strict | input | 1 | Enforces even size fields for transmit |
| req_valid | output | 1 | Transfer request valid |
| req_ready | input | 1 | Transfer request accepted |
| req_addr | output | 40 | Cache-block byte address |
| req_offset | output | 5 | Header byte offset of this request |
| req_buf | output | 1 | 0 for buffer A, 1 for buffer B |
| done | output | 1 | Descriptor finished (one-cycle pulse) |
| irq | output | 1 | Interrupt request, asserted with done |
| err | output | 1 | Malformed descriptor, asserted with done |
| next_ptr | output | 40 | Next-descriptor address in chain mode |
| next_ptr_valid | output | 1 | next_ptr is meaningful, asserted with done |
| rx_status | input | 13 | Receive status to write back |
| rx_len | input | 14 | Receive packet length to write back |
| wb_a | output | 64 | Write-back first word |
| wb_b | output | 64 | Write-back second word |

## Verification
A descriptor is accepted on the edge where `dscr_valid` and `dscr_ready` are both 1. The first request is offered in the next cycle. Each request moves on one edge after it is accepted, and `done` together with `irq`, `err`, `next_ptr` and the write-back words comes in the cycle after the final accepted request, or in the cycle right after acceptance for a malformed descriptor. The bench drives its inputs and samples every output on the falling edge. It treats a request as accepted only when `req_valid` and its own `req_ready` are both high in that half cycle. It compares each accepted request with the k-th entry of a sequence it builds from the descriptor fields. It waits for `done` while counting requests, so the cycle count is checked through the request count and the position of the pulse.

// File: rtl/walker_pkg.sv
package walker_pkg;
    localparam int DW       = 64;
    localparam int ADDR_W   = 40;
    localparam int BLK_LOG2 = 5;
    localparam int SIZE_W   = 9;
    localparam int CNT_W    = SIZE_W + 1;
    localparam int OFF_W    = 5;
    localparam int STAT_W   = 13;
    localparam int LEN_W    = 14;

    // field positions fixed by the descriptor format
    localparam int ADDR_LO  = 5;
    localparam int ADDR_HI  = 39;
    localparam int LINK_LO  = 4;
    localparam int SIZE_LO  = 40;
    localparam int SIZE_HI  = SIZE_LO + SIZE_W - 1;
    localparam int IRQ_BIT  = 49;
    localparam int OFFB_BIT = 50;
    localparam int BV_BIT   = 49;
    localparam int STAT_LO  = DW - STAT_W;
    localparam int LEN_LO   = DW - LEN_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WALK_A,
        ST_WALK_B,
        ST_FINISH
    } walk_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] base_a;
        logic [ADDR_W-1:0] base_b;
        logic [ADDR_W-1:0] link;
        logic [CNT_W-1:0]  blk_a;
        logic [CNT_W-1:0]  blk_b;
        logic [OFF_W-1:0]  hdr_off;
        logic              irq_req;
        logic              offs_b;
        logic              b_used;
    } walk_plan_t;

    function automatic logic [CNT_W-1:0] blocks_of(input logic [SIZE_W-1:0] sz);
        return (sz == '0) ? CNT_W'(1 << SIZE_W) : {1'b0, sz};
    endfunction
endpackage

// File: rtl/walker_decode.sv
module walker_decode
    import walker_pkg::*;
(
    input  logic [DW-1:0] word_a,
    input  logic [DW-1:0] word_b,
    input  logic          chain,
    input  logic          strict,
    output walk_plan_t    plan,
    output logic          bad
);
    logic offb_bad;
    logic size_bad;

    always_comb begin
        plan.base_a  = {word_a[ADDR_HI:ADDR_LO], BLK_LOG2'(0)};
        plan.base_b  = {word_b[ADDR_HI:ADDR_LO], BLK_LOG2'(0)};
        plan.link    = {word_b[ADDR_HI:LINK_LO], LINK_LO'(0)};
        plan.blk_a   = blocks_of(word_a[SIZE_HI:SIZE_LO]);
        plan.blk_b   = blocks_of(word_b[SIZE_HI:SIZE_LO]);
        plan.hdr_off = word_a[OFF_W-1:0];
        plan.irq_req = word_a[IRQ_BIT];
        plan.offs_b  = word_a[OFFB_BIT];
        plan.b_used  = !chain && word_b[BV_BIT];
        offb_bad     = word_a[OFFB_BIT] && (chain || !word_b[BV_BIT]);
        size_bad     = strict && (word_a[SIZE_LO] || (plan.b_used && word_b[SIZE_LO]));
        bad          = offb_bad || size_bad;
    end
endmodule

// File: rtl/walker_addr_gen.sv
module walker_addr_gen
    import walker_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  blocks,
    output logic [CNT_W-1:0]  cnt,
    output logic              last,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    always_comb begin
        last = (cnt == blocks - 1'b1);
        addr = base + (ADDR_W'(cnt) << BLK_LOG2);
    end
endmodule

// File: rtl/dma_dscr_walker.sv
module dma_dscr_walker
    import walker_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dscr_valid,
    output logic              dscr_ready,
    input  logic [DW-1:0]     dscr_a,
    input  logic [DW-1:0]     dscr_b,
    input  logic              chain_mode,
    input  logic              tx_strict,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [OFF_W-1:0]  req_offset,
    output logic              req_buf,
    output logic              done,
    output logic              irq,
    output logic              err,
    output logic [ADDR_W-1:0] next_ptr,
    output logic              next_ptr_valid,
    input  logic [STAT_W-1:0] rx_status,
    input  logic [LEN_W-1:0]  rx_len,
    output logic [DW-1:0]     wb_a,
    output logic [DW-1:0]     wb_b
);
    walk_state_t       state, state_nx;
    logic [DW-1:0]     a_q, b_q;
    logic              chain_q, strict_q, err_q;
    logic [DW-1:0]     dec_a, dec_b;
    logic              dec_chain, dec_strict;
    walk_plan_t        plan;
    logic              bad;
    logic              accept, fire, last;
    logic              cnt_clr;
    logic [ADDR_W-1:0] cur_base;
    logic [CNT_W-1:0]  cur_blocks;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] gen_addr;

    // while idle, decode the incoming words; otherwise the held ones
    always_comb begin
        dec_a      = (state == ST_IDLE) ? dscr_a     : a_q;
        dec_b      = (state == ST_IDLE) ? dscr_b     : b_q;
        dec_chain  = (state == ST_IDLE) ? chain_mode : chain_q;
        dec_strict = (state == ST_IDLE) ? tx_strict  : strict_q;
    end

    walker_decode u_dec (
        .word_a (dec_a),
        .word_b (dec_b),
        .chain  (dec_chain),
        .strict (dec_strict),
        .plan   (plan),
        .bad    (bad)
    );

    always_comb begin
        accept     = (state == ST_IDLE) && dscr_valid;
        fire       = req_valid && req_ready;
        cur_base   = (state == ST_WALK_B) ? plan.base_b : plan.base_a;
        cur_blocks = (state == ST_WALK_B) ? plan.blk_b  : plan.blk_a;
        cnt_clr    = accept || (fire && last);
    end

    walker_addr_gen u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .inc    (fire && !last),
        .base   (cur_base),
        .blocks (cur_blocks),
        .cnt    (cnt),
        .last   (last),
        .addr   (gen_addr)
    );

    // held descriptor
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q      <= '0;
            b_q      <= '0;
            chain_q  <= 1'b0;
            strict_q <= 1'b0;
            err_q    <= 1'b0;
        end else if (accept) begin
            a_q      <= dscr_a;
            b_q      <= dscr_b;
            chain_q  <= chain_mode;
            strict_q <= tx_strict;
            err_q    <= bad;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (dscr_valid) state_nx = bad ? ST_FINISH : ST_WALK_A;
            ST_WALK_A: if (fire && last) state_nx = plan.b_used ? ST_WALK_B : ST_FINISH;
            ST_WALK_B: if (fire && last) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        dscr_ready     = 1'b0;
        req_valid      = 1'b0;
        req_buf        = 1'b0;
        req_offset     = '0;
        done           = 1'b0;
        irq            = 1'b0;
        err            = 1'b0;
        next_ptr_valid = 1'b0;
        unique case (state)
            ST_IDLE:   dscr_ready = 1'b1;
            ST_WALK_A: begin
                req_valid = 1'b1;
                if (cnt == '0 && !plan.offs_b) req_offset = plan.hdr_off;
            end
            ST_WALK_B: begin
                req_valid = 1'b1;
                req_buf   = 1'b1;
                if (cnt == '0 && plan.offs_b) req_offset = plan.hdr_off;
            end
            ST_FINISH: begin
                done           = 1'b1;
                err            = err_q;
                irq            = !err_q && plan.irq_req;
                next_ptr_valid = !err_q && chain_q;
            end
            default:   dscr_ready = 1'b0;
        endcase
        req_addr = gen_addr;
        next_ptr = plan.link;
        wb_a     = {rx_status, a_q[STAT_LO-1:0]};
        wb_b     = {rx_len, b_q[LEN_LO-1:0]};
    end
endmodule

// File: rtl/walker_checker.sv
module walker_checker
    import walker_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              dscr_ready,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [OFF_W-1:0]  req_offset,
    input logic              req_buf,
    input logic              done,
    input logic              irq,
    input logic              err,
    input logic              next_ptr_valid
);
    assert_idle_no_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && dscr_ready));

    assert_block_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(req_valid && req_ready) && req_buf == $past(req_buf))
        |-> req_addr == $past(req_addr) + ADDR_W'(1 << BLK_LOG2));

    assert_offset_first_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(req_valid && req_ready) && req_buf == $past(req_buf))
        |-> req_offset == '0);

    assert_err_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && !irq && !next_ptr_valid));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_irq_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);

    assert_hold_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=>
        (req_valid && $stable(req_addr) && $stable(req_offset) && $stable(req_buf)));
endmodule

bind dma_dscr_walker walker_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .dscr_ready     (dscr_ready),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_addr       (req_addr),
    .req_offset     (req_offset),
    .req_buf        (req_buf),
    .done           (done),
    .irq            (irq),
    .err            (err),
    .next_ptr_valid (next_ptr_valid)
);

// File: tb/sim_dma_dscr_walker.sv
module sim_dma_dscr_walker;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dscr_valid = 1'b0;
    logic        dscr_ready;
    logic [63:0] dscr_a = '0;
    logic [63:0] dscr_b = '0;
    logic        chain_mode = 1'b0;
    logic        tx_strict = 1'b0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [39:0] req_addr;
    logic [4:0]  req_offset;
    logic        req_buf;
    logic        done, irq, err;
    logic [39:0] next_ptr;
    logic        next_ptr_valid;
    logic [12:0] rx_status = '0;
    logic [13:0] rx_len = '0;
    logic [63:0] wb_a, wb_b;

    int n_chk = 0;
    int n_bad = 0;

    dma_dscr_walker u0 (.*);

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int nblk(input logic [8:0] sz);
        return (sz == 0) ? 512 : int'(sz);
    endfunction

    // one descriptor, with req_ready low on every stall_mod-th cycle (0: never)
    task automatic walk(input logic [63:0] a, input logic [63:0] b, input bit chain,
                        input bit strict, input int stall_mod, input string tag);
        bit b_used, offb, bad, got_done;
        int na, nb, k, cyc;
        logic [39:0] ea;
        logic [4:0]  eo;
        logic        eb;
        b_used = !chain && b[49];
        offb   = a[50];
        bad    = (offb && (chain || !b[49])) || (strict && (a[40] || (b_used && b[40])));
        na     = bad ? 0 : nblk(a[48:40]);
        nb     = (bad || !b_used) ? 0 : nblk(b[48:40]);
        rx_status = 13'h1ABC ^ a[63:51];
        rx_len    = 14'h2D5A ^ b[63:50];
        @(negedge clk);
        check(dscr_ready == 1'b1, {tag, " R1 ready before accept"}, 64'(dscr_ready), 64'd1);
        dscr_a = a; dscr_b = b; chain_mode = chain; tx_strict = strict; dscr_valid = 1'b1;
        @(negedge clk);
        dscr_valid = 1'b0;
        dscr_a = '1; dscr_b = '1; chain_mode = !chain; tx_strict = 1'b0;
        k = 0; cyc = 0; got_done = 0;
        while (!got_done && cyc < 3000) begin
            req_ready = (stall_mod == 0) || ((cyc % stall_mod) != 0);
            #1;
            if (done) begin
                got_done = 1;
                check(k == na + nb, {tag, " R8 done after last request"}, 64'(k), 64'(na + nb));
                check(err == bad, {tag, " R6 R7 err flag"}, 64'(err), 64'(bad));
                check(irq == (a[49] && !bad), {tag, " R8 irq"}, 64'(irq), 64'(a[49] && !bad));
                check(next_ptr_valid == (chain && !bad), {tag, " R4 next_ptr_valid"},
                      64'(next_ptr_valid), 64'(chain && !bad));
                if (chain && !bad)
                    check(next_ptr == {b[39:4], 4'b0}, {tag, " R4 next_ptr"},
                          64'(next_ptr), 64'({b[39:4], 4'b0}));
                check(wb_a == {rx_status, a[50:0]}, {tag, " R10 wb_a"}, wb_a, {rx_status, a[50:0]});
                check(wb_b == {rx_len, b[49:0]}, {tag, " R10 wb_b"}, wb_b, {rx_len, b[49:0]});
            end else if (req_valid && req_ready) begin
                if (k < na) begin
                    ea = {a[39:5], 5'b0} + 40'(32 * k);
                    eo = (k == 0 && !offb) ? a[4:0] : 5'd0;
                    eb = 1'b0;
                end else begin
                    ea = {b[39:5], 5'b0} + 40'(32 * (k - na));
                    eo = (k == na && offb) ? a[4:0] : 5'd0;
                    eb = 1'b1;
                end
                check(req_addr == ea, {tag, " R2 R3 request address"}, 64'(req_addr), 64'(ea));
                check(req_offset == eo, {tag, " R5 request offset"}, 64'(req_offset), 64'(eo));
                check(req_buf == eb, {tag, " R3 request buffer"}, 64'(req_buf), 64'(eb));
                k++;
            end
            @(negedge clk);
            cyc++;
        end
        req_ready = 1'b0;
        check(got_done, {tag, " R8 done seen"}, 64'(got_done), 64'd1);
        #1;
        check(done == 1'b0, {tag, " R8 done is one cycle"}, 64'(done), 64'd0);
    endtask

    task automatic reset_check;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(dscr_ready == 1 && req_valid == 0 && done == 0 && irq == 0 && err == 0,
              "R1 reset outputs", {59'd0, dscr_ready, req_valid, done, irq, err}, 64'h10);
        rst_n = 1'b1;
    endtask

    task automatic stall_hold_R9;
        logic [39:0] held;
        @(negedge clk);
        dscr_a = {13'd0, 2'b00, 9'd3, 35'h12345, 5'd0}; dscr_b = '0;
        chain_mode = 1'b0; tx_strict = 1'b0; dscr_valid = 1'b1; req_ready = 1'b0;
        @(negedge clk);
        dscr_valid = 1'b0;
        held = req_addr;
        repeat (4) @(negedge clk);
        check(req_valid == 1'b1 && req_addr == held, "R9 request held while stalled",
              64'(req_addr), 64'(held));
        req_ready = 1'b1;
        repeat (3) @(negedge clk);
        req_ready = 1'b0;
        #1;
        check(done == 1'b1, "R9 done after stalled walk", 64'(done), 64'd1);
        @(negedge clk);
    endtask

    // word A: {status, offb, irq, size, addr, off}; word B: {len, bvalid, size, addr, bit4, opts}
    function automatic logic [63:0] mk_a(input logic [12:0] st, input bit offb, input bit ir,
                                         input logic [8:0] sz, input logic [34:0] ad, input logic [4:0] off);
        return {st, offb, ir, sz, ad, off};
    endfunction
    function automatic logic [63:0] mk_b(input logic [13:0] ln, input bit bv, input logic [8:0] sz,
                                         input logic [34:0] ad, input bit b4, input logic [3:0] op);
        return {ln, bv, sz, ad, b4, op};
    endfunction

    initial begin : watchdog
        #(CLK_P * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        reset_check();
        walk(mk_a(13'h0, 0, 0, 9'd4, 35'h0_0100, 5'd7), mk_b(14'h5, 0, 9'd9, 35'h7_FFFF, 0, 4'h3), 0, 0, 0, "ring A only R3");
        walk(mk_a(13'h11, 0, 1, 9'd2, 35'h0_0200, 5'd3), mk_b(14'h40, 1, 9'd3, 35'h0_0800, 0, 4'h1), 0, 0, 3, "ring A+B R3");
        walk(mk_a(13'h2, 1, 0, 9'd1, 35'h1_0000, 5'd31), mk_b(14'h7, 1, 9'd2, 35'h2_0000, 0, 4'h0), 0, 0, 0, "offset on B R5");
        walk(mk_a(13'h3, 0, 1, 9'd0, 35'h7_FFFF_FFF0, 5'd1), mk_b(14'h0, 0, 9'd0, 35'h0, 0, 4'h0), 0, 0, 0, "zero size 512 R2");
        walk(mk_a(13'h4, 0, 1, 9'd511, 35'h3_0000, 5'd0), mk_b(14'h9, 1, 9'd1, 35'h4_0000, 0, 4'h0), 0, 0, 5, "size 511 R2");
        walk(mk_a(13'h5, 0, 0, 9'd3, 35'h0_0400, 5'd2), mk_b(14'h33, 1, 9'd5, 35'h5_5555, 1, 4'h0), 1, 0, 0, "chain R4");
        walk(mk_a(13'h6, 1, 1, 9'd3, 35'h0_0400, 5'd2), mk_b(14'h1, 1, 9'd5, 35'h5_5555, 1, 4'h0), 1, 0, 0, "offb in chain R6");
        walk(mk_a(13'h7, 1, 1, 9'd3, 35'h0_0400, 5'd2), mk_b(14'h1, 0, 9'd5, 35'h5_5555, 0, 4'h0), 0, 0, 0, "offb no bvalid R6");
        walk(mk_a(13'h8, 0, 1, 9'd3, 35'h0_0600, 5'd0), mk_b(14'h1, 0, 9'd4, 35'h0, 0, 4'h0), 0, 1, 0, "strict odd A R7");
        walk(mk_a(13'h9, 0, 0, 9'd2, 35'h0_0600, 5'd0), mk_b(14'h1, 1, 9'd5, 35'h6_0000, 0, 4'h0), 0, 1, 0, "strict odd B R7");
        walk(mk_a(13'hA, 0, 1, 9'd2, 35'h0_0600, 5'd4), mk_b(14'h2, 0, 9'd5, 35'h6_0000, 0, 4'h0), 0, 1, 0, "strict unused odd B R7");
        walk(mk_a(13'hB, 0, 0, 9'd3, 35'h0_0700, 5'd0), mk_b(14'h2, 0, 9'd5, 35'h6_0000, 0, 4'h0), 0, 0, 2, "no strict odd R7");
        stall_hold_R9();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule